// File: doc/BRIEF.md
# Bit-Select Reset PWM Generator

A single-channel pulse-width modulator clocked by a fast system clock and advanced by a slow tick enable, normally pulsed at 32 kHz. One 8-bit up-counter sets the period. It has no period register. A 2-bit prescaler picks which counter bit clears the counter as soon as that bit would become set. The bits below that bit are the active count. Prescaler values 0 through 3 give periods of 128, 64, 32 and 16 ticks. At 32 kHz these are 4, 2, 1 and 0.5 ms, or 250 Hz, 500 Hz, 1 kHz and 2 kHz.

Software reaches the block through a two-register port: a one-bit address, write data, write enable and combinational read data. Register 0 holds the enable and the prescaler. Register 1 holds a 7-bit duty value. Both registers take effect on the clock edge of the write, with no end-of-period shadowing. A prescaler change leaves the counter as it is, so one period of irregular length can follow the change.

Top module: `bitsel_pwm`

## Requirements
- R1: After reset both registers read back as 0x00 and `pwm_out` is low.
- R2: Address 0 reads the enable in bit 7 and the prescaler in bits 1:0, with bits 6:2 as zero. Address 1 reads the duty in bits 6:0, with bit 7 as zero. Writes to the unused bits are discarded.
- R3: With the block enabled, the output period is 2^(7-prescaler) ticks: 128, 64, 32 or 16. The counter clears when the next count would set bit (7-prescaler).
- R4: `pwm_out` is high exactly while the active counter bits are strictly less than the duty value. The high time per period is therefore min(duty, period) ticks, and it begins at count zero.
- R5: When the prescaler is 1 to 3 and the duty is at least the period, the output stays high. When the prescaler is 0, the largest duty of 127 gives 127 high ticks out of 128, and the output is never continuously high.
- R6: A duty of 0 keeps the output low.
- R7: While the enable is 0, the output is low and the counter is held at zero. After the enable is set again, the period starts at count zero.
- R8: The counter changes only on clock edges where `tick` is high.
- R9: A duty write changes the output on the edge of the write, in the middle of a period.
- R10: A prescaler write does not clear the counter. Starting from count 40, a switch to prescaler 3 keeps the output low until 8 more ticks have arrived, and only then does the period restart at count zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable, one clock wide, nominally 32 kHz |
| addr | input | 1 | Register select: 0 control, 1 duty |
| wdata | input | 8 | Write data |
| we | input | 1 | Write strobe |
| rdata | output | 8 | Read data for the selected register |
| pwm_out | output | 1 | PWM output |

## Verification
Every result appears on the clock edge that causes it. A register write becomes visible on `rdata` and `pwm_out` at the same edge that stores it, and each tick edge moves `pwm_out` to its value for the new count at that edge. The bench changes inputs on falling edges and samples on the falling edge straight after the edge of interest. The scoreboard monitor takes its first sample on the falling edge where the enabling write completes, which is count zero. After that it takes one sample per tick over two whole periods and compares the high count and the spacing between rising edges with the queued expectation.

// File: rtl/bitsel_pwm.sv
module bitsel_pwm #(
  parameter int CNT_W = 8,
  parameter int PSC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             addr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             we,
  output logic [CNT_W-1:0] rdata,
  output logic             pwm_out
);
  localparam int DUTY_W = CNT_W - 1;
  localparam int IDX_W  = $clog2(CNT_W);
  localparam int GAP_W  = CNT_W - 1 - PSC_W;

  logic              en;
  logic [PSC_W-1:0]  psc;
  logic [DUTY_W-1:0] duty;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cnt_inc;
  logic [CNT_W-1:0]  act_mask;
  logic [IDX_W-1:0]  rst_bit;

  assign rst_bit  = IDX_W'(CNT_W - 1) - IDX_W'(psc);
  assign cnt_inc  = cnt + 1'b1;
  assign act_mask = (CNT_W'(1) << rst_bit) - 1'b1;
  assign pwm_out  = en && ((cnt & act_mask) < {1'b0, duty});
  assign rdata    = addr ? {1'b0, duty} : {en, {GAP_W{1'b0}}, psc};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      psc  <= '0;
      duty <= '0;
    end else if (we) begin
      if (addr) duty <= wdata[DUTY_W-1:0];
      else begin
        en  <= wdata[CNT_W-1];
        psc <= wdata[PSC_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!en)            cnt <= '0;
    else if (tick)           cnt <= cnt_inc[rst_bit] ? '0 : cnt_inc;
  end
endmodule

// File: rtl/bitsel_pwm_chk.sv
module bitsel_pwm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       en,
  input logic [1:0] psc,
  input logic [6:0] duty,
  input logic [7:0] cnt,
  input logic       addr,
  input logic [7:0] rdata,
  input logic       pwm_out
);
  assert_dis_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pwm_out);
  assert_dis_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == 8'd0));
  assert_no_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(cnt));
  assert_full_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && psc != 2'd0 && {1'b0, duty} >= (8'd128 >> psc)) |-> pwm_out);
  assert_zero_duty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == 7'd0) |-> !pwm_out);
  assert_rd_duty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr |-> !rdata[7]);
  assert_rd_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !addr |-> (rdata[6:2] == 5'd0));
endmodule

bind bitsel_pwm bitsel_pwm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .psc(psc), .duty(duty),
  .cnt(cnt), .addr(addr), .rdata(rdata), .pwm_out(pwm_out)
);

// File: tb/tb_bitsel_pwm.sv
module tb_bitsel_pwm;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, addr = 1'b0, we = 1'b0;
  logic [7:0] wdata = 8'd0, rdata;
  logic pwm_out;
  int errors = 0, checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bitsel_pwm dut (.clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr),
                  .wdata(wdata), .we(we), .rdata(rdata), .pwm_out(pwm_out));

  typedef struct { string tag; int per; int high; int rise_gap; } item_t;
  item_t sb[$];
  bit mon_done = 1'b0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  // driver: restart from count zero, queue the expectation, supply ticks
  task automatic run_case(string tag, int p, int d);
    item_t it;
    int per = 128 >> p;
    int hi = (d < per) ? d : per;
    wr(1'b0, 8'(p));
    wr(1'b1, 8'(d));
    wr(1'b0, 8'h80 | 8'(p));
    it.tag = tag; it.per = per; it.high = 2 * hi;
    it.rise_gap = (d > 0 && d < per) ? per : 0;
    mon_done = 1'b0;
    sb.push_back(it);
    ticks(2 * per);
    wait (mon_done);
  endtask

  // monitor: one sample at count zero, then one after every tick edge
  initial begin
    forever begin
      item_t it;
      int hi, r1, r2;
      logic prev, s;
      wait (sb.size() > 0);
      it = sb.pop_front();
      hi = 0; r1 = -1; r2 = -1; prev = 1'b1;
      for (int k = 0; k <= 2 * it.per; k++) begin
        if (k > 0) begin
          @(posedge clk iff tick);
          @(negedge clk);
        end
        s = pwm_out;
        if (k < 2 * it.per && s) hi++;
        if (k > 0 && s && !prev) begin
          if (r1 < 0) r1 = k; else if (r2 < 0) r2 = k;
        end
        prev = s;
      end
      check({it.tag, " high ticks"}, hi, it.high);
      check({it.tag, " rise spacing"}, (r2 >= 0) ? r2 - r1 : 0, it.rise_gap);
      mon_done = 1'b1;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    check("R1 output low", int'(pwm_out), 0);
    rd(1'b0, d); check("R1 control reset", int'(d), 0);
    rd(1'b1, d); check("R1 duty reset", int'(d), 0);
    rst_n = 1'b1;

    wr(1'b0, 8'hFF); rd(1'b0, d); check("R2 control readback", int'(d), 8'h83);
    wr(1'b1, 8'hFF); rd(1'b1, d); check("R2 duty readback", int'(d), 8'h7F);

    run_case("R3 R4 psc0 duty64", 0, 64);
    run_case("R4 psc0 duty1", 0, 1);
    run_case("R5 psc0 duty127", 0, 127);
    run_case("R6 psc0 duty0", 0, 0);
    run_case("R3 R4 psc1 duty32", 1, 32);
    run_case("R5 psc1 full", 1, 64);
    run_case("R3 R4 psc2 duty10", 2, 10);
    run_case("R5 psc2 full", 2, 32);
    run_case("R3 R4 psc3 duty5", 3, 5);
    run_case("R5 psc3 full", 3, 16);
    run_case("R5 psc3 duty20", 3, 20);

    // R7: disable clears and holds the counter
    wr(1'b0, 8'h01); wr(1'b1, 8'd10); wr(1'b0, 8'h81);
    ticks(20);
    check("R7 running low at count 20", int'(pwm_out), 0);
    wr(1'b0, 8'h01);
    ticks(5);
    check("R7 disabled output", int'(pwm_out), 0);
    wr(1'b0, 8'h81);
    check("R7 restart at count zero", int'(pwm_out), 1);

    // R8: no tick, no count
    wr(1'b0, 8'h03); wr(1'b1, 8'd5); wr(1'b0, 8'h83);
    ticks(4);
    repeat (40) @(negedge clk);
    check("R8 held without tick", int'(pwm_out), 1);
    ticks(1);
    check("R8 moves on tick", int'(pwm_out), 0);

    // R9: immediate duty update
    wr(1'b0, 8'h00); wr(1'b1, 8'd10); wr(1'b0, 8'h80);
    ticks(20);
    check("R9 before duty write", int'(pwm_out), 0);
    wr(1'b1, 8'd100);
    check("R9 after duty write", int'(pwm_out), 1);

    // R10: prescaler switch keeps the count
    wr(1'b0, 8'h00); wr(1'b1, 8'd5); wr(1'b0, 8'h80);
    ticks(40);
    wr(1'b0, 8'h83);
    check("R10 at switch", int'(pwm_out), 0);
    ticks(7);
    check("R10 glitch period low", int'(pwm_out), 0);
    ticks(1);
    check("R10 wrap after 8 ticks", int'(pwm_out), 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule